// File: doc/BRIEF.md
# Configuration Control Packet Parser

This block sits on a 32-bit word stream with valid/ready flow control and splits it into configuration control packets. Each packet opens with a routing header word, followed by a command header word, and, for the two write kinds, by one to four payload words. The parser checks both header words against an inverted parity rule. It extracts the routing fields (packet type, packet ID) and the command fields (stream ID, opcode, word count, address), and derives a target column and row from the address. For every well-formed packet it emits one command beat on its output channel, then passes each payload word through as a data beat tagged with its position.

Faults are reported as one-cycle error pulses: a header parity mismatch, an opcode value with no meaning, or a stream that ends (its last flag set) before a packet is complete. After a parity or opcode fault the parser discards words through the next last flag, then treats the following word as a fresh routing header. The output channel has a single register stage. While that stage is full and not being taken, the parser stops accepting words that would produce output, so no accepted word is ever lost.

Top module: `ctrl_pkt_parser`

## Requirements
- R1: For each header word, the rule is that bit 31 equals 1 exactly when the number of ones in bits 30:0 is even. A routing or command header that breaks this rule produces an `err_parity` pulse and no command beat.
- R2: The command beat reports the packet type from bits 14:12 and the packet ID from bits 7:0 of the routing header (the first word of a packet). All other bits of that word, except parity, are ignored.
- R3: A command beat (`out_kind` = 0) is produced only after the command header (the second word) is accepted. It reports stream ID from bits 30:24, opcode from bits 23:22 and address from bits 19:0, with `out_count` equal to the beats field (bits 21:20) plus one.
- R4: For opcode 0 (write) and opcode 2 (block write), exactly beats+1 payload words follow. Each is output as a data beat (`out_kind` = 1) carrying the word unchanged, with `out_index` counting 0, 1, … in arrival order. The word after the last payload word is taken as a new routing header.
- R5: For opcode 1 (read), no payload is taken, `out_count` still reports beats+1, and the next word is taken as a new routing header.
- R6: For opcode 3, the parser produces an `err_opcode` pulse and no command beat, and it consumes no payload for that packet.
- R7: An `err_trunc` pulse is produced when the last flag arrives on a routing header, on the command header of a write, or on a payload word that is not the final one. Beats already accepted are still output, and the next word is taken as a routing header.
- R8: After a parity or opcode error, words produce no output up to and including the next word with the last flag. The following word is taken as a routing header. If the faulty word itself carries the last flag, resynchronisation is immediate.
- R9: The command beat reports the column as bits [COL_SHIFT+4:COL_SHIFT] and the row as bits [ROW_SHIFT+4:ROW_SHIFT] of the zero-extended address.
- R10: While `out_valid` is high and `out_ready` is low, every output field holds its value. No word that would produce output is accepted in that state, and no accepted word is lost.
- R11: After reset, `out_valid` and all error flags are low and `in_ready` is high, with a routing header expected.
- R12: Each accepted word raises at most one error flag, with priority parity over opcode over truncation. Flags rise in the cycle after the word is accepted and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can take a word |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Word ends the stream |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_kind | output | 1 | 0 = command beat, 1 = data beat |
| out_pkt_type | output | 3 | Packet type |
| out_pkt_id | output | 8 | Packet ID |
| out_stream_id | output | 7 | Stream ID |
| out_opcode | output | 2 | Opcode |
| out_addr | output | 20 | Target address |
| out_count | output | 3 | Words to write or read (1 to 4) |
| out_col | output | 5 | Column field of the address |
| out_row | output | 5 | Row field of the address |
| out_data | output | 32 | Payload word (data beats) |
| out_index | output | 2 | Payload word position (data beats) |
| err_parity | output | 1 | Header parity fault pulse |
| err_opcode | output | 1 | Illegal opcode pulse |
| err_trunc | output | 1 | Early end-of-stream pulse |

## Verification
The bench sweeps every opcode against every beat count, with clean headers and with each header's parity broken, under both a free and a randomly stalled consumer. A parser that used plain even parity would flag every clean packet, and one that counted payload from the wrong field would swallow or leak words and desynchronise every packet after it. Truncation is tried at each possible payload position, including on the command header itself. This catches a parser that waits past the last flag, or one that reports the fault yet keeps dropping the next packet. Lone routing headers ending the stream, an illegal opcode combined with bad parity, and packets chained without a last flag probe error priority and resynchronisation. A stalled consumer exposes a parser that overwrites its output register or drops a word it accepted.

// File: rtl/ctrl_pkt_pkg.sv
package ctrl_pkt_pkg;

    localparam int WORD_W  = 32;
    localparam int TYPE_W  = 3;
    localparam int ID_W    = 8;
    localparam int SID_W   = 7;
    localparam int OP_W    = 2;
    localparam int BEATS_W = 2;
    localparam int CNT_W   = BEATS_W + 1;
    localparam int ADDR_W  = 20;

    // field positions inside the header words
    localparam int TYPE_LSB  = 12;
    localparam int ID_LSB    = 0;
    localparam int SID_LSB   = 24;
    localparam int OP_LSB    = 22;
    localparam int BEATS_LSB = 20;
    localparam int ADDR_LSB  = 0;

    localparam logic [OP_W-1:0] OP_WRITE   = 2'd0;
    localparam logic [OP_W-1:0] OP_READ    = 2'd1;
    localparam logic [OP_W-1:0] OP_BLKWR   = 2'd2;
    localparam logic [OP_W-1:0] OP_ILLEGAL = 2'd3;

    localparam logic KIND_CMD  = 1'b0;
    localparam logic KIND_DATA = 1'b1;

    typedef enum logic [1:0] {
        ST_STREAM_HDR = 2'd0,
        ST_CTRL_HDR   = 2'd1,
        ST_PAYLOAD    = 2'd2,
        ST_DROP       = 2'd3
    } cpp_state_e;

endpackage

// File: rtl/cpp_parity_chk.sv
module cpp_parity_chk #(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    output logic         ok
);
    // top bit must be set when the lower bits hold an even number of ones
    assign ok = (word[W-1] == ~(^word[W-2:0]));
endmodule

// File: rtl/cpp_hdr_decode.sv
module cpp_hdr_decode
    import ctrl_pkt_pkg::*;
#(
    parameter int COL_SHIFT = 15,
    parameter int ROW_SHIFT = 10,
    parameter int TILE_W    = 5
) (
    input  logic [WORD_W-2:0]  word,
    output logic [TYPE_W-1:0]  pkt_type,
    output logic [ID_W-1:0]    pkt_id,
    output logic [SID_W-1:0]   stream_id,
    output logic [OP_W-1:0]    opcode,
    output logic [BEATS_W-1:0] beats,
    output logic [ADDR_W-1:0]  addr,
    output logic [TILE_W-1:0]  col,
    output logic [TILE_W-1:0]  row,
    output logic               has_payload,
    output logic               illegal
);
    localparam int N_TILE = 2;

    logic [WORD_W-1:0] addr_ext;
    logic [TILE_W-1:0] tile_f [N_TILE];

    // routing header view
    assign pkt_type  = word[TYPE_LSB +: TYPE_W];
    assign pkt_id    = word[ID_LSB +: ID_W];

    // command header view
    assign stream_id = word[SID_LSB +: SID_W];
    assign opcode    = word[OP_LSB +: OP_W];
    assign beats     = word[BEATS_LSB +: BEATS_W];
    assign addr      = word[ADDR_LSB +: ADDR_W];

    assign has_payload = (opcode == OP_WRITE) || (opcode == OP_BLKWR);
    assign illegal     = (opcode == OP_ILLEGAL);

    assign addr_ext = WORD_W'(addr);

    // index 0: row field, index 1: column field
    generate
        for (genvar g = 0; g < N_TILE; g++) begin : g_tile
            localparam int SH = (g == 0) ? ROW_SHIFT : COL_SHIFT;
            assign tile_f[g] = TILE_W'(addr_ext >> SH);
        end
    endgenerate

    assign row = tile_f[0];
    assign col = tile_f[1];
endmodule

// File: rtl/ctrl_pkt_parser.sv
module ctrl_pkt_parser
    import ctrl_pkt_pkg::*;
#(
    parameter int COL_SHIFT = 15,
    parameter int ROW_SHIFT = 10,
    parameter int TILE_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_kind,
    output logic [TYPE_W-1:0]  out_pkt_type,
    output logic [ID_W-1:0]    out_pkt_id,
    output logic [SID_W-1:0]   out_stream_id,
    output logic [OP_W-1:0]    out_opcode,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [CNT_W-1:0]   out_count,
    output logic [TILE_W-1:0]  out_col,
    output logic [TILE_W-1:0]  out_row,
    output logic [WORD_W-1:0]  out_data,
    output logic [BEATS_W-1:0] out_index,
    output logic               err_parity,
    output logic               err_opcode,
    output logic               err_trunc
);
    typedef struct packed {
        cpp_state_e         state;
        logic [TYPE_W-1:0]  hdr_type;
        logic [ID_W-1:0]    hdr_id;
        logic [BEATS_W-1:0] remain;
        logic [BEATS_W-1:0] beat_idx;
        logic               o_valid;
        logic               o_kind;
        logic [TYPE_W-1:0]  o_type;
        logic [ID_W-1:0]    o_id;
        logic [SID_W-1:0]   o_sid;
        logic [OP_W-1:0]    o_op;
        logic [ADDR_W-1:0]  o_addr;
        logic [CNT_W-1:0]   o_cnt;
        logic [TILE_W-1:0]  o_col;
        logic [TILE_W-1:0]  o_row;
        logic [WORD_W-1:0]  o_data;
        logic [BEATS_W-1:0] o_index;
        logic               e_par;
        logic               e_op;
        logic               e_trunc;
    } regs_t;

    regs_t r_q, r_d;

    logic               par_ok;
    logic [TYPE_W-1:0]  dec_type;
    logic [ID_W-1:0]    dec_id;
    logic [SID_W-1:0]   dec_sid;
    logic [OP_W-1:0]    dec_op;
    logic [BEATS_W-1:0] dec_beats;
    logic [ADDR_W-1:0]  dec_addr;
    logic [TILE_W-1:0]  dec_col;
    logic [TILE_W-1:0]  dec_row;
    logic               dec_has_pl;
    logic               dec_illegal;
    logic               out_free;
    logic               accept;
    cpp_state_e         err_state;
    cpp_state_e         state_q;

    cpp_parity_chk #(
        .W (WORD_W)
    ) u_parity (
        .word (in_data),
        .ok   (par_ok)
    );

    cpp_hdr_decode #(
        .COL_SHIFT (COL_SHIFT),
        .ROW_SHIFT (ROW_SHIFT),
        .TILE_W    (TILE_W)
    ) u_decode (
        .word        (in_data[WORD_W-2:0]),
        .pkt_type    (dec_type),
        .pkt_id      (dec_id),
        .stream_id   (dec_sid),
        .opcode      (dec_op),
        .beats       (dec_beats),
        .addr        (dec_addr),
        .col         (dec_col),
        .row         (dec_row),
        .has_payload (dec_has_pl),
        .illegal     (dec_illegal)
    );

    assign state_q  = r_q.state;
    assign out_free = !r_q.o_valid || out_ready;
    assign in_ready = (r_q.state == ST_STREAM_HDR || r_q.state == ST_DROP) ? 1'b1 : out_free;
    assign accept   = in_valid && in_ready;
    assign err_state = in_last ? ST_STREAM_HDR : ST_DROP;

    always_comb begin
        r_d         = r_q;
        r_d.e_par   = 1'b0;
        r_d.e_op    = 1'b0;
        r_d.e_trunc = 1'b0;
        if (r_q.o_valid && out_ready) begin
            r_d.o_valid = 1'b0;
        end

        if (accept) begin
            unique case (r_q.state)
                ST_STREAM_HDR: begin
                    r_d.hdr_type = dec_type;
                    r_d.hdr_id   = dec_id;
                    if (!par_ok) begin
                        r_d.e_par = 1'b1;
                        r_d.state = err_state;
                    end else if (in_last) begin
                        r_d.e_trunc = 1'b1;
                        r_d.state   = ST_STREAM_HDR;
                    end else begin
                        r_d.state = ST_CTRL_HDR;
                    end
                end
                ST_CTRL_HDR: begin
                    if (!par_ok) begin
                        r_d.e_par = 1'b1;
                        r_d.state = err_state;
                    end else if (dec_illegal) begin
                        r_d.e_op  = 1'b1;
                        r_d.state = err_state;
                    end else begin
                        r_d.o_valid = 1'b1;
                        r_d.o_kind  = KIND_CMD;
                        r_d.o_type  = r_q.hdr_type;
                        r_d.o_id    = r_q.hdr_id;
                        r_d.o_sid   = dec_sid;
                        r_d.o_op    = dec_op;
                        r_d.o_addr  = dec_addr;
                        r_d.o_cnt   = CNT_W'(dec_beats) + CNT_W'(1);
                        r_d.o_col   = dec_col;
                        r_d.o_row   = dec_row;
                        if (!dec_has_pl) begin
                            r_d.state = ST_STREAM_HDR;
                        end else if (in_last) begin
                            r_d.e_trunc = 1'b1;
                            r_d.state   = ST_STREAM_HDR;
                        end else begin
                            r_d.state    = ST_PAYLOAD;
                            r_d.remain   = dec_beats;
                            r_d.beat_idx = '0;
                        end
                    end
                end
                ST_PAYLOAD: begin
                    r_d.o_valid = 1'b1;
                    r_d.o_kind  = KIND_DATA;
                    r_d.o_data  = in_data;
                    r_d.o_index = r_q.beat_idx;
                    if (r_q.remain == '0) begin
                        r_d.state = ST_STREAM_HDR;
                    end else if (in_last) begin
                        r_d.e_trunc = 1'b1;
                        r_d.state   = ST_STREAM_HDR;
                    end else begin
                        r_d.remain   = r_q.remain - 1'b1;
                        r_d.beat_idx = r_q.beat_idx + 1'b1;
                    end
                end
                ST_DROP: begin
                    if (in_last) begin
                        r_d.state = ST_STREAM_HDR;
                    end
                end
                default: r_d.state = ST_STREAM_HDR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid     = r_q.o_valid;
    assign out_kind      = r_q.o_kind;
    assign out_pkt_type  = r_q.o_type;
    assign out_pkt_id    = r_q.o_id;
    assign out_stream_id = r_q.o_sid;
    assign out_opcode    = r_q.o_op;
    assign out_addr      = r_q.o_addr;
    assign out_count     = r_q.o_cnt;
    assign out_col       = r_q.o_col;
    assign out_row       = r_q.o_row;
    assign out_data      = r_q.o_data;
    assign out_index     = r_q.o_index;
    assign err_parity    = r_q.e_par;
    assign err_opcode    = r_q.e_op;
    assign err_trunc     = r_q.e_trunc;
endmodule

// File: rtl/ctrl_pkt_parser_chk.sv
module ctrl_pkt_parser_chk
    import ctrl_pkt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_last,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_kind,
    input logic [OP_W-1:0]    out_opcode,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [CNT_W-1:0]   out_count,
    input logic [WORD_W-1:0]  out_data,
    input logic [BEATS_W-1:0] out_index,
    input logic               err_parity,
    input logic               err_opcode,
    input logic               err_trunc,
    input cpp_state_e         state
);
    logic taken;
    assign taken = in_valid && in_ready;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_kind)
            && $stable(out_index) && $stable(out_addr) && $stable(out_opcode)); // R10

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && (state == ST_CTRL_HDR || state == ST_PAYLOAD) |-> !in_ready); // R10

    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_parity, err_opcode, err_trunc})); // R12

    AST_NO_ILLEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == KIND_CMD |-> out_opcode != OP_ILLEGAL); // R6

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == KIND_DATA |-> CNT_W'(out_index) < out_count); // R4

    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DROP && !(taken && in_last) |=> state == ST_DROP); // R8

    AST_DROP_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DROP && taken && in_last |=> state == ST_STREAM_HDR); // R8

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DROP && !out_valid |=> !out_valid); // R8
endmodule

bind ctrl_pkt_parser ctrl_pkt_parser_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_kind   (out_kind),
    .out_opcode (out_opcode),
    .out_addr   (out_addr),
    .out_count  (out_count),
    .out_data   (out_data),
    .out_index  (out_index),
    .err_parity (err_parity),
    .err_opcode (err_opcode),
    .err_trunc  (err_trunc),
    .state      (state_q)
);

// File: tb/ctrl_pkt_parser_bench.sv
module ctrl_pkt_parser_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_SH = 15;
    localparam int ROW_SH = 10;
    localparam int QN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready;
    logic        out_kind;
    logic [2:0]  out_pkt_type;
    logic [7:0]  out_pkt_id;
    logic [6:0]  out_stream_id;
    logic [1:0]  out_opcode;
    logic [19:0] out_addr;
    logic [2:0]  out_count;
    logic [4:0]  out_col;
    logic [4:0]  out_row;
    logic [31:0] out_data;
    logic [1:0]  out_index;
    logic        err_parity;
    logic        err_opcode;
    logic        err_trunc;

    ctrl_pkt_parser #(.COL_SHIFT(COL_SH), .ROW_SHIFT(ROW_SH), .TILE_W(5)) u_ctrl_pkt_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_pkt_type(out_pkt_type), .out_pkt_id(out_pkt_id),
        .out_stream_id(out_stream_id), .out_opcode(out_opcode), .out_addr(out_addr),
        .out_count(out_count), .out_col(out_col), .out_row(out_row), .out_data(out_data),
        .out_index(out_index), .err_parity(err_parity), .err_opcode(err_opcode),
        .err_trunc(err_trunc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit        ex_kind [QN];
    bit [52:0] ex_cmd  [QN];
    bit [33:0] ex_dat  [QN];
    int ex_wr = 0, ex_rd = 0;
    int exp_par = 0, exp_op = 0, exp_tr = 0;
    int obs_par = 0, obs_op = 0, obs_tr = 0;
    bit stall_mode = 1'b0;
    bit [31:0] rng = 32'h1234_5678;
    bit [31:0] srng = 32'hCAFE_0101;
    bit        prev_stall = 1'b0;
    bit [31:0] prev_data;
    bit        prev_kind;
    bit [1:0]  prev_idx;
    bit        done = 1'b0;

    task automatic rnd(output bit [31:0] v);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        v = rng;
    endtask

    // header word: top bit set when the 31 low bits have an even count of ones
    function automatic bit [31:0] seal(bit [30:0] raw, bit flip);
        int ones = 0;
        for (int i = 0; i < 31; i++) ones += raw[i];
        return {((ones % 2) == 0) ^ flip, raw};
    endfunction

    // monitor: drives out_ready, consumes output beats, counts error pulses
    always @(negedge clk) begin
        if (!rst_n) begin
            out_ready = 1'b1;
            prev_stall = 1'b0;
        end else begin
            srng = srng ^ (srng << 13);
            srng = srng ^ (srng >> 17);
            srng = srng ^ (srng << 5);
            out_ready = stall_mode ? srng[3] : 1'b1;
            if (prev_stall) begin
                checks++;
                if (!out_valid || out_data != prev_data || out_kind != prev_kind || out_index != prev_idx) begin
                    errors++;
                    $display("FAIL R10 stalled beat changed: got v=%0b d=%h k=%0b i=%0d exp v=1 d=%h k=%0b i=%0d",
                             out_valid, out_data, out_kind, out_index, prev_data, prev_kind, prev_idx);
                end
            end
            if (out_valid && out_ready) begin
                checks++;
                if (ex_rd == ex_wr) begin
                    errors++;
                    $display("FAIL R4 unexpected beat: got kind=%0b data=%h exp none", out_kind, out_data);
                end else begin
                    if (out_kind != ex_kind[ex_rd % QN]) begin
                        errors++;
                        $display("FAIL R3 beat kind: got %0b exp %0b", out_kind, ex_kind[ex_rd % QN]);
                    end else if (out_kind == 1'b0) begin
                        if ({out_pkt_type, out_pkt_id, out_stream_id, out_opcode, out_addr, out_count, out_col, out_row}
                            != ex_cmd[ex_rd % QN]) begin
                            errors++;
                            $display("FAIL R2/R3/R9 command: got %h exp %h",
                                {out_pkt_type, out_pkt_id, out_stream_id, out_opcode, out_addr, out_count, out_col, out_row},
                                ex_cmd[ex_rd % QN]);
                        end
                    end else if ({out_data, out_index} != ex_dat[ex_rd % QN]) begin
                        errors++;
                        $display("FAIL R4 payload: got %h exp %h", {out_data, out_index}, ex_dat[ex_rd % QN]);
                    end
                    ex_rd++;
                end
            end
            if (err_parity) obs_par++;
            if (err_opcode) obs_op++;
            if (err_trunc) obs_tr++;
            if (err_parity || err_opcode || err_trunc) begin
                checks++;
                if ((32'(err_parity) + 32'(err_opcode) + 32'(err_trunc)) > 1) begin
                    errors++;
                    $display("FAIL R12 several flags: got %b exp one", {err_parity, err_opcode, err_trunc});
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data = out_data;
            prev_kind = out_kind;
            prev_idx = out_index;
        end
    end

    task automatic send(input bit [31:0] w, input bit last);
        in_valid = 1'b1;
        in_data = w;
        in_last = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        repeat (2) @(negedge clk);
        while (ex_rd != ex_wr && n < 300) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        #2;
        checks++;
        if (ex_rd != ex_wr || obs_par != exp_par || obs_op != exp_op || obs_tr != exp_tr) begin
            errors++;
            $display("FAIL %s: got pend=%0d par=%0d op=%0d tr=%0d exp pend=0 par=%0d op=%0d tr=%0d",
                     tag, ex_wr - ex_rd, obs_par, obs_op, obs_tr, exp_par, exp_op, exp_tr);
        end
    endtask

    // bad: 0 clean, 1 routing header parity, 2 command header parity
    // cut: -1 full packet, else payload words sent before the stream ends
    task automatic run_pkt(input int op, input int beats, input int bad, input int cut, input bit end_last);
        bit [31:0] r1, r2, r3;
        bit [31:0] w [6];
        bit [30:0] sraw, craw;
        bit [31:0] a32;
        int n, npl;
        bit err, lastf;
        rnd(r1); rnd(r2); rnd(r3);
        sraw = r1[30:0];
        sraw[14:12] = r2[2:0];
        sraw[7:0] = r2[10:3];
        craw = {r3[26:20], 2'(op), 2'(beats), r3[19:0]};
        w[0] = seal(sraw, bad == 1);
        w[1] = seal(craw, bad == 2);
        n = 2;
        npl = (op == 1) ? 0 : beats + 1;
        if (cut >= 0) npl = cut;
        for (int i = 0; i < npl; i++) begin
            rnd(w[n]);
            n++;
        end
        err = (bad != 0) || (op == 3);
        lastf = err || (cut >= 0) || end_last;
        if (bad != 0) exp_par++;
        else if (op == 3) exp_op++;
        else begin
            a32 = {12'd0, r3[19:0]};
            ex_kind[ex_wr % QN] = 1'b0;
            ex_cmd[ex_wr % QN] = {r2[2:0], r2[10:3], r3[26:20], 2'(op), r3[19:0], 3'(beats + 1),
                                  5'((a32 / (32'd1 << COL_SH)) % 32), 5'((a32 / (32'd1 << ROW_SH)) % 32)};
            ex_wr++;
            for (int i = 0; i < npl; i++) begin
                ex_kind[ex_wr % QN] = 1'b1;
                ex_dat[ex_wr % QN] = {w[2 + i], 2'(i)};
                ex_wr++;
            end
            if (cut >= 0) exp_tr++;
        end
        for (int i = 0; i < n; i++) send(w[i], lastf && (i == n - 1));
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        checks++;
        if (out_valid || !in_ready || err_parity || err_opcode || err_trunc) begin
            errors++;
            $display("FAIL R11 reset: got v=%0b rdy=%0b err=%b exp v=0 rdy=1 err=000",
                     out_valid, in_ready, {err_parity, err_opcode, err_trunc});
        end
        @(negedge clk);

        // sweep: opcode x beats x parity fault, free and stalled consumer
        for (int m = 0; m < 2; m++) begin
            stall_mode = (m == 1);
            for (int op = 0; op < 4; op++)
                for (int b = 0; b < 4; b++)
                    for (int bad = 0; bad < 3; bad++) begin
                        run_pkt(op, b, bad, -1, 1'b1);
                        if (bad != 0 && op == 3) drain("R12 parity over opcode");
                        else if (bad != 0) drain("R1 parity");
                        else if (op == 3) drain("R6 illegal opcode");
                        else if (op == 1) drain("R5 read");
                        else drain("R4 write");
                    end
            // truncation at each payload position
            for (int op = 0; op < 3; op += 2)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c <= b; c++) begin
                        run_pkt(op, b, 0, c, 1'b1);
                        drain("R7 truncation");
                    end
            // several packets inside one stream
            run_pkt(2, 3, 0, -1, 1'b0);
            run_pkt(1, 2, 0, -1, 1'b0);
            run_pkt(0, 1, 0, -1, 1'b0);
            run_pkt(2, 0, 0, -1, 1'b1);
            drain("R4 chained packets");
            // error then immediate recovery
            run_pkt(3, 2, 0, -1, 1'b1);
            run_pkt(0, 2, 0, -1, 1'b1);
            drain("R8 resync after opcode fault");
            run_pkt(2, 1, 1, -1, 1'b1);
            run_pkt(1, 3, 0, -1, 1'b0);
            run_pkt(2, 2, 0, -1, 1'b1);
            drain("R8 resync after parity fault");
        end
        stall_mode = 1'b0;

        // lone routing header ending the stream
        send(seal(31'h0000_5A5A, 1'b0), 1'b1);
        exp_tr++;
        drain("R7 stream ends after routing header");
        // lone routing header with bad parity ending the stream
        send(seal(31'h0000_0000, 1'b1), 1'b1);
        exp_par++;
        drain("R12 parity over truncation");
        run_pkt(0, 3, 0, -1, 1'b1);
        drain("R8 immediate resync");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule